// File: doc/BRIEF.md
# Host Port Interrupt and Command Unit

This unit is the DSP-side interrupt logic of a parallel host port. The host loads words into a receive data register, and the DSP takes them out. The DSP loads words into a transmit data register, and the host takes them out. Two status flags follow these registers: receive-full and transmit-empty. A DSP control register holds one enable per interrupt source. It also holds two flag bits that go out to the host. The status register holds the pending conditions and two flag bits that come in from the host.

The host also writes a command vector register. That register has a request bit and a 7-bit vector number. When the command interrupt is enabled, the request forces the core to the interrupt address that is twice the vector number. This lets the host start any one of 128 routines. Three masked requests leave the unit, along with a single combined request and the address of the highest-priority active source. The core's acknowledge of a host command withdraws that command. The two data flags are cleared only by DSP data accesses.

Top module: `hpi_irq_unit`

## Requirements
- R1: After reset, every control bit is 0, the command vector register is 0x00, receive-full is 0 and transmit-empty is 1. No interrupt request is active and `irq_vec_o` is 0.
- R2: A host write to the receive register stores the word and sets receive-full (status bit 0) on the next cycle. The word appears on `dsp_rx_data_o`.
- R3: A DSP read of the receive register clears receive-full on the next cycle. If a host write arrives in the same cycle, the flag stays set.
- R4: A DSP write to the transmit register stores the word and clears transmit-empty (status bit 1). A host read of the transmit register sets it. If both happen in the same cycle, the flag ends cleared.
- R5: Each request output is active exactly when its status flag and its enable are both set. The pairs are: receive at control/status bit 0, transmit at bit 1, command at bit 2.
- R6: In the command vector register, bit 7 is the request bit and bits 6:0 are the vector number. A host write made while bit 7 is clear stores the whole byte. Status bit 2 shows bit 7.
- R7: A host write to the command vector register made while bit 7 is set is ignored. The register keeps its value until the acknowledge clears the request.
- R8: When the command request is presented, `irq_vec_o` equals twice the vector number.
- R9: Priority is command, then receive, then transmit. Only the winner's address appears on `irq_vec_o`: `2*vector` for the command, `RX_VEC` (default 0x20) for receive, `TX_VEC` (default 0x22) for transmit, and 0 when nothing is active.
- R10: `irq_ack_i` while the command is the presented source clears bit 7 on the next cycle and keeps the vector bits. `irq_ack_i` while a data source is presented leaves every flag unchanged.
- R11: Control bits 4:3 drive `host_flags_o`. `host_flags_i` appears on status bits 4:3 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_rx_wr_i | input | 1 | Host writes receive register |
| host_rx_data_i | input | DW | Host write data |
| host_tx_rd_i | input | 1 | Host reads transmit register |
| host_tx_data_o | output | DW | Transmit register contents |
| host_cvr_wr_i | input | 1 | Host writes command vector register |
| host_cvr_data_i | input | HVW+1 | Command vector write data |
| host_cvr_o | output | HVW+1 | Command vector register contents |
| host_flags_i | input | 2 | Flags from host to DSP |
| host_flags_o | output | 2 | Flags from DSP to host |
| dsp_rx_rd_i | input | 1 | DSP reads receive register |
| dsp_rx_data_o | output | DW | Receive register contents |
| dsp_tx_wr_i | input | 1 | DSP writes transmit register |
| dsp_tx_data_i | input | DW | DSP write data |
| dsp_ctrl_wr_i | input | 1 | DSP writes control register |
| dsp_ctrl_data_i | input | 5 | Control write data |
| dsp_ctrl_o | output | 5 | Control register |
| dsp_stat_o | output | 5 | Status register |
| irq_rx_o | output | 1 | Masked receive-full request |
| irq_tx_o | output | 1 | Masked transmit-empty request |
| irq_cmd_o | output | 1 | Masked host command request |
| irq_req_o | output | 1 | Any request active |
| irq_vec_o | output | HVW+1 | Address of highest-priority request |
| irq_ack_i | input | 1 | Core acknowledge of presented request |

## Verification
The hardest case to reach is a command vector write that lands while a command is still pending. A dependent case is an acknowledge that must clear the command but no data flag. The stimulus first posts a command with the command interrupt masked, so that no acknowledge can take it. It then overwrites the register and pulses the acknowledge, and checks that both have no effect. After that it enables the command while receive-full is also raised. It checks the vector hand-off from the command to receive, and checks that receive-full survives the acknowledge.

// File: rtl/hpi_pkg.sv
package hpi_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_CMD  = 2'd1,
    SRC_RX   = 2'd2,
    SRC_TX   = 2'd3
  } irq_src_e;

  localparam int unsigned BIT_RX   = 0;
  localparam int unsigned BIT_TX   = 1;
  localparam int unsigned BIT_CMD  = 2;
  localparam int unsigned NUM_SRC  = 3;
  localparam int unsigned FLAG_LSB = 3;
  localparam int unsigned FLAG_W   = 2;
  localparam int unsigned REG_W    = NUM_SRC + FLAG_W;
endpackage

// File: rtl/hpi_data_regs.sv
module hpi_data_regs #(
  parameter int unsigned DW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          host_rx_wr_i,
  input  logic [DW-1:0] host_rx_data_i,
  input  logic          dsp_rx_rd_i,
  input  logic          host_tx_rd_i,
  input  logic          dsp_tx_wr_i,
  input  logic [DW-1:0] dsp_tx_data_i,
  output logic [DW-1:0] rx_data_o,
  output logic [DW-1:0] tx_data_o,
  output logic          rx_full_o,
  output logic          tx_empty_o
);
  logic [DW-1:0] rx_q, tx_q;
  logic          rxf_q, txe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q  <= '0;
      rxf_q <= 1'b0;
    end else begin
      if (host_rx_wr_i) rx_q <= host_rx_data_i;
      // new host data wins over a concurrent DSP read
      if (host_rx_wr_i)     rxf_q <= 1'b1;
      else if (dsp_rx_rd_i) rxf_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q  <= '0;
      txe_q <= 1'b1;
    end else begin
      if (dsp_tx_wr_i) tx_q <= dsp_tx_data_i;
      // fresh DSP data is unread, so the write wins over a host read
      if (dsp_tx_wr_i)       txe_q <= 1'b0;
      else if (host_tx_rd_i) txe_q <= 1'b1;
    end
  end

  assign rx_data_o  = rx_q;
  assign tx_data_o  = tx_q;
  assign rx_full_o  = rxf_q;
  assign tx_empty_o = txe_q;

  assert_rx_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rx_wr_i |=> rx_full_o);
  assert_rx_clr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dsp_rx_rd_i && !host_rx_wr_i) |=> !rx_full_o);
  assert_tx_clr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dsp_tx_wr_i |=> (!tx_empty_o && tx_data_o == $past(dsp_tx_data_i)));
endmodule

// File: rtl/hpi_cmd_vec.sv
module hpi_cmd_vec #(
  parameter int unsigned HVW = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         host_wr_i,
  input  logic [HVW:0] host_data_i,
  input  logic         ack_cmd_i,
  output logic [HVW:0] cvr_o
);
  logic [HVW:0] cvr_q;
  logic         pend;

  assign pend = cvr_q[HVW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cvr_q <= '0;
    end else if (pend) begin
      if (ack_cmd_i) cvr_q[HVW] <= 1'b0;
    end else if (host_wr_i) begin
      cvr_q <= host_data_i;
    end
  end

  assign cvr_o = cvr_q;

  assert_cvr_locked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend && !ack_cmd_i) |=> $stable(cvr_o));
  assert_ack_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend && ack_cmd_i) |=> (!cvr_o[HVW] && cvr_o[HVW-1:0] == $past(cvr_q[HVW-1:0])));
  assert_cvr_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend && host_wr_i) |=> cvr_o == $past(host_data_i));
endmodule

// File: rtl/hpi_irq_arb.sv
module hpi_irq_arb
  import hpi_pkg::*;
#(
  parameter int unsigned HVW    = 7,
  parameter logic [HVW:0] RX_VEC = 8'h20,
  parameter logic [HVW:0] TX_VEC = 8'h22
) (
  input  logic [NUM_SRC-1:0] flag_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic [HVW-1:0]     hv_i,
  input  logic               ack_i,
  output logic [NUM_SRC-1:0] req_o,
  output logic               any_o,
  output logic [HVW:0]       vec_o,
  output logic               ack_cmd_o
);
  irq_src_e sel;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_mask
    assign req_o[g] = flag_i[g] & en_i[g];
  end

  always_comb begin
    if (req_o[BIT_CMD])     sel = SRC_CMD;
    else if (req_o[BIT_RX]) sel = SRC_RX;
    else if (req_o[BIT_TX]) sel = SRC_TX;
    else                    sel = SRC_NONE;
  end

  always_comb begin
    case (sel)
      SRC_CMD: vec_o = {hv_i, 1'b0};
      SRC_RX:  vec_o = RX_VEC;
      SRC_TX:  vec_o = TX_VEC;
      default: vec_o = '0;
    endcase
  end

  assign any_o     = |req_o;
  assign ack_cmd_o = ack_i & (sel == SRC_CMD);

  always_comb begin
    assert_one_src_R9: assert ($countones({sel == SRC_CMD, sel == SRC_RX, sel == SRC_TX}) == 32'(any_o));
  end
endmodule

// File: rtl/hpi_irq_unit.sv
module hpi_irq_unit
  import hpi_pkg::*;
#(
  parameter int unsigned  DW     = 24,
  parameter int unsigned  HVW    = 7,
  parameter logic [HVW:0] RX_VEC = 8'h20,
  parameter logic [HVW:0] TX_VEC = 8'h22
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             host_rx_wr_i,
  input  logic [DW-1:0]    host_rx_data_i,
  input  logic             host_tx_rd_i,
  output logic [DW-1:0]    host_tx_data_o,
  input  logic             host_cvr_wr_i,
  input  logic [HVW:0]     host_cvr_data_i,
  output logic [HVW:0]     host_cvr_o,
  input  logic [1:0]       host_flags_i,
  output logic [1:0]       host_flags_o,
  input  logic             dsp_rx_rd_i,
  output logic [DW-1:0]    dsp_rx_data_o,
  input  logic             dsp_tx_wr_i,
  input  logic [DW-1:0]    dsp_tx_data_i,
  input  logic             dsp_ctrl_wr_i,
  input  logic [4:0]       dsp_ctrl_data_i,
  output logic [4:0]       dsp_ctrl_o,
  output logic [4:0]       dsp_stat_o,
  output logic             irq_rx_o,
  output logic             irq_tx_o,
  output logic             irq_cmd_o,
  output logic             irq_req_o,
  output logic [HVW:0]     irq_vec_o,
  input  logic             irq_ack_i
);
  logic [REG_W-1:0]   ctrl_q;
  logic [NUM_SRC-1:0] flags, req;
  logic               rx_full, tx_empty, ack_cmd;
  logic [HVW:0]       cvr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            ctrl_q <= '0;
    else if (dsp_ctrl_wr_i) ctrl_q <= dsp_ctrl_data_i;
  end

  hpi_data_regs #(.DW(DW)) u_data (
    .clk_i, .rst_ni,
    .host_rx_wr_i, .host_rx_data_i, .dsp_rx_rd_i,
    .host_tx_rd_i, .dsp_tx_wr_i, .dsp_tx_data_i,
    .rx_data_o  (dsp_rx_data_o),
    .tx_data_o  (host_tx_data_o),
    .rx_full_o  (rx_full),
    .tx_empty_o (tx_empty)
  );

  hpi_cmd_vec #(.HVW(HVW)) u_cmd (
    .clk_i, .rst_ni,
    .host_wr_i   (host_cvr_wr_i),
    .host_data_i (host_cvr_data_i),
    .ack_cmd_i   (ack_cmd),
    .cvr_o       (cvr)
  );

  assign flags[BIT_RX]  = rx_full;
  assign flags[BIT_TX]  = tx_empty;
  assign flags[BIT_CMD] = cvr[HVW];

  hpi_irq_arb #(.HVW(HVW), .RX_VEC(RX_VEC), .TX_VEC(TX_VEC)) u_arb (
    .flag_i    (flags),
    .en_i      (ctrl_q[NUM_SRC-1:0]),
    .hv_i      (cvr[HVW-1:0]),
    .ack_i     (irq_ack_i),
    .req_o     (req),
    .any_o     (irq_req_o),
    .vec_o     (irq_vec_o),
    .ack_cmd_o (ack_cmd)
  );

  assign irq_rx_o     = req[BIT_RX];
  assign irq_tx_o     = req[BIT_TX];
  assign irq_cmd_o    = req[BIT_CMD];
  assign host_cvr_o   = cvr;
  assign host_flags_o = ctrl_q[FLAG_LSB +: FLAG_W];
  assign dsp_ctrl_o   = ctrl_q;
  assign dsp_stat_o   = {host_flags_i, flags};

  assert_cmd_vec_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_cmd_o |-> irq_vec_o == {host_cvr_o[HVW-1:0], 1'b0});
  assert_rx_prio_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_rx_o && !irq_cmd_o) |-> irq_vec_o == RX_VEC);
  assert_mask_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_rx_o || irq_tx_o || irq_cmd_o) |-> ((dsp_stat_o[2:0] & dsp_ctrl_o[2:0]) != 3'b000));
  assert_data_ack_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && !irq_cmd_o && !dsp_rx_rd_i && !host_rx_wr_i) |=> $stable(dsp_stat_o[0]));
endmodule

// File: tb/hpi_irq_unit_tb.sv
module hpi_irq_unit_tb;
  localparam int DW = 24;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          host_rx_wr_i = 0, host_tx_rd_i = 0, host_cvr_wr_i = 0;
  logic [DW-1:0] host_rx_data_i = '0, dsp_tx_data_i = '0;
  logic [7:0]    host_cvr_data_i = '0;
  logic [1:0]    host_flags_i = '0;
  logic          dsp_rx_rd_i = 0, dsp_tx_wr_i = 0, dsp_ctrl_wr_i = 0, irq_ack_i = 0;
  logic [4:0]    dsp_ctrl_data_i = '0;
  logic [DW-1:0] host_tx_data_o, dsp_rx_data_o;
  logic [7:0]    host_cvr_o, irq_vec_o;
  logic [1:0]    host_flags_o;
  logic [4:0]    dsp_ctrl_o, dsp_stat_o;
  logic          irq_rx_o, irq_tx_o, irq_cmd_o, irq_req_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  hpi_irq_unit u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic set_ctrl(input logic [4:0] v);
    dsp_ctrl_data_i = v; dsp_ctrl_wr_i = 1; tick(); dsp_ctrl_wr_i = 0;
  endtask

  task automatic cvr_write(input logic [7:0] v);
    host_cvr_data_i = v; host_cvr_wr_i = 1; tick(); host_cvr_wr_i = 0;
  endtask

  task automatic t_reset();
    chk("R1 ctrl", dsp_ctrl_o, 0);
    chk("R1 cvr", host_cvr_o, 0);
    chk("R1 stat", dsp_stat_o[2:0], 3'b010);
    chk("R1 req", {irq_req_o, irq_rx_o, irq_tx_o, irq_cmd_o}, 0);
    chk("R1 vec", irq_vec_o, 0);
  endtask

  task automatic t_rx();
    host_rx_data_i = 24'hA5C3E1; host_rx_wr_i = 1; tick(); host_rx_wr_i = 0;
    chk("R2 rxf", dsp_stat_o[0], 1);
    chk("R2 data", dsp_rx_data_o, 24'hA5C3E1);
    dsp_rx_rd_i = 1; tick(); dsp_rx_rd_i = 0;
    chk("R3 clear", dsp_stat_o[0], 0);
    host_rx_data_i = 24'h123456; host_rx_wr_i = 1; tick(); host_rx_wr_i = 0;
    host_rx_data_i = 24'h00BEEF; host_rx_wr_i = 1; dsp_rx_rd_i = 1; tick();
    host_rx_wr_i = 0; dsp_rx_rd_i = 0;
    chk("R3 collide", dsp_stat_o[0], 1);
    chk("R2 newdata", dsp_rx_data_o, 24'h00BEEF);
    dsp_rx_rd_i = 1; tick(); dsp_rx_rd_i = 0;
    chk("R3 clear2", dsp_stat_o[0], 0);
  endtask

  task automatic t_tx();
    dsp_tx_data_i = 24'h5A5A01; dsp_tx_wr_i = 1; tick(); dsp_tx_wr_i = 0;
    chk("R4 clr", dsp_stat_o[1], 0);
    chk("R4 data", host_tx_data_o, 24'h5A5A01);
    host_tx_rd_i = 1; tick(); host_tx_rd_i = 0;
    chk("R4 set", dsp_stat_o[1], 1);
    dsp_tx_data_i = 24'h777777; dsp_tx_wr_i = 1; host_tx_rd_i = 1; tick();
    dsp_tx_wr_i = 0; host_tx_rd_i = 0;
    chk("R4 collide", dsp_stat_o[1], 0);
    host_tx_rd_i = 1; tick(); host_tx_rd_i = 0;
    chk("R4 set2", dsp_stat_o[1], 1);
  endtask

  task automatic t_mask();
    chk("R5 masked", {irq_tx_o, irq_req_o}, 0);
    set_ctrl(5'b00010);
    chk("R5 tx on", {irq_rx_o, irq_tx_o, irq_cmd_o}, 3'b010);
    chk("R9 tx vec", irq_vec_o, 8'h22);
    set_ctrl(5'b00001);
    chk("R5 rx en no flag", {irq_req_o}, 0);
    host_rx_wr_i = 1; tick(); host_rx_wr_i = 0;
    chk("R5 rx on", {irq_rx_o, irq_tx_o}, 2'b10);
    dsp_rx_rd_i = 1; tick(); dsp_rx_rd_i = 0;
    set_ctrl(5'b00000);
  endtask

  task automatic t_cmd_lock();
    cvr_write(8'h83);
    chk("R6 load", host_cvr_o, 8'h83);
    chk("R6 hcp", dsp_stat_o[2], 1);
    chk("R5 cmd masked", irq_cmd_o, 0);
    cvr_write(8'h05);
    chk("R7 ignored", host_cvr_o, 8'h83);
    irq_ack_i = 1; tick(); irq_ack_i = 0;
    chk("R10 ack not presented", host_cvr_o, 8'h83);
    set_ctrl(5'b00100);
    chk("R8 vec", irq_vec_o, 8'h06);
    irq_ack_i = 1; tick(); irq_ack_i = 0;
    chk("R10 ack clr", host_cvr_o, 8'h03);
    chk("R10 req gone", irq_cmd_o, 0);
    cvr_write(8'h05);
    chk("R6 no req write", host_cvr_o, 8'h05);
    chk("R6 hcp off", dsp_stat_o[2], 0);
  endtask

  task automatic t_prio();
    set_ctrl(5'b00111);
    host_rx_wr_i = 1; tick(); host_rx_wr_i = 0;
    chk("R9 rx over tx", irq_vec_o, 8'h20);
    cvr_write(8'hD5);
    chk("R9 cmd first", irq_vec_o, 8'hAA);
    chk("R9 all req", {irq_rx_o, irq_tx_o, irq_cmd_o, irq_req_o}, 4'hF);
    irq_ack_i = 1; tick(); irq_ack_i = 0;
    chk("R10 cmd done", irq_vec_o, 8'h20);
    irq_ack_i = 1; tick(); irq_ack_i = 0;
    chk("R10 rx kept", dsp_stat_o[1:0], 2'b11);
    cvr_write(8'hFF);
    chk("R8 max vec", irq_vec_o, 8'hFE);
    irq_ack_i = 1; tick(); irq_ack_i = 0;
    dsp_rx_rd_i = 1; tick(); dsp_rx_rd_i = 0;
    chk("R9 tx last", irq_vec_o, 8'h22);
    set_ctrl(5'b00101);
    chk("R9 none", {irq_req_o, irq_vec_o}, 9'h0);
  endtask

  task automatic t_flags();
    set_ctrl(5'b10000);
    chk("R11 out", host_flags_o, 2'b10);
    set_ctrl(5'b01000);
    chk("R11 out2", host_flags_o, 2'b01);
    host_flags_i = 2'b10; #1;
    chk("R11 in", dsp_stat_o[4:3], 2'b10);
    host_flags_i = 2'b01; #1;
    chk("R11 in2", dsp_stat_o[4:3], 2'b01);
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #12; rst_ni = 1; tick();
    t_reset();
    t_rx();
    t_tx();
    t_mask();
    t_cmd_lock();
    t_prio();
    t_flags();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule